// File: doc/BRIEF.md
# Event/Gate Counter with Synchronized Output

This block is an up counter driven by an external event input. Run-time control bits choose one of two ways to count. In edge mode each selected transition of the input advances the counter by one. In gate mode the input works as a level gate, and a prescaled clock enable advances the counter on every cycle in which the input sits at the selected level.

A compare register sets the wrap point. When the counter is at the compare value and a count arrives, it returns to zero and a divider output toggles. The result is a generated output clock. The pin drive follows that clock only while an effective enable is set. Changes to the enable bit written by software are held off until the next edge of the output clock of the kind chosen by an edge-select bit. The same bit also gives the starting level of the divider whenever software writes the counter. All state changes on the rising edge of `clk`.

Top module: `evgate_counter`

## Requirements
- R1: On reset the counter is 0, `clk_out` and `pin_out` are 0, all four control bits are 0 and the compare register is all ones.
- R2: Edge mode (control bit 0 = 0). The event input passes through a two-flop synchronizer. Each falling edge advances the counter by exactly one when control bit 1 is 0. Each rising edge does so when control bit 1 is 1. Edges of the other direction have no effect.
- R3: Gate mode (control bit 0 = 1). The counter advances by one on each cycle in which `presc_en` is 1 and the synchronized input equals control bit 1 (0 means low enables, 1 means high enables).
- R4: If a count arrives while the counter equals the compare value, the counter reloads to 0 and `clk_out` toggles. Any other count adds one and leaves `clk_out` unchanged.
- R5: A counter write loads `wr_data` into the counter on the next edge and sets `clk_out` to the current value of control bit 3.
- R6: A counter write in the same cycle as a count takes priority, and that count is lost.
- R7: A change of control bit 2 (the output enable) reaches the pin only at the next edge of `clk_out` selected by control bit 3 (0 means falling, 1 means rising).
- R8: While the effective enable is 0, `pin_out` is 0. Once the enable has taken effect, `pin_out` equals `clk_out`.
- R9: Write port: when `wr_en` is 1, `wr_sel` = 0 writes the control bits (bit 0 mode, bit 1 polarity, bit 2 output enable, bit 3 edge select), `wr_sel` = 1 writes the counter and `wr_sel` = 2 writes the compare register. `wr_sel` = 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 counter, 2 compare |
| wr_data | input | W | Write data |
| evt_in | input | 1 | External event input, asynchronous |
| presc_en | input | 1 | Prescaled clock enable, used in gate mode |
| count | output | W | Current counter value |
| clk_out | output | 1 | Divider output clock |
| pin_out | output | 1 | Pin drive, gated by the synchronized enable |

## Verification
On every cycle the embedded assertions check the following:
- a counter write loads its data;
- a cycle with no count leaves the counter and divider unchanged;
- a count below the compare value adds exactly one;
- a count at the compare value wraps to zero and toggles the divider;
- the effective enable changes only right after the divider has moved.

Only the bench scenarios can show the rest, because it depends on choosing the stimulus:
- edge selection (rising against falling) and level selection;
- the exact counts after long gate windows;
- the wrap period for each compare value;
- the held-off enable, visible as a divider pulse that does not reach the pin.

// File: rtl/evgate_counter.sv
module evgate_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         evt_in,
  input  logic         presc_en,
  output logic [W-1:0] count,
  output logic         clk_out,
  output logic         pin_out
);

  logic [1:0] sync;
  logic       prev;
  logic       mode, pol, oe, edge_sel;
  logic [W-1:0] cmp;
  logic       div, div_d, oe_eff;

  wire s        = sync[1];
  wire ev_edge  = pol ? (s & ~prev) : (~s & prev);
  wire gate_ok  = presc_en & (s == pol);
  wire tick     = mode ? gate_ok : ev_edge;
  wire wr_ctl   = wr_en && (wr_sel == 2'd0);
  wire wr_cnt   = wr_en && (wr_sel == 2'd1);
  wire wr_cmp   = wr_en && (wr_sel == 2'd2);
  wire at_match = (count == cmp);
  wire act_edge = edge_sel ? (div & ~div_d) : (~div & div_d);

  assign clk_out = div;
  assign pin_out = oe_eff & div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= 2'b00;
      prev <= 1'b0;
    end else begin
      sync <= {sync[0], evt_in};
      prev <= sync[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= 1'b0;
      pol      <= 1'b0;
      oe       <= 1'b0;
      edge_sel <= 1'b0;
      cmp      <= '1;
    end else begin
      if (wr_ctl) begin
        mode     <= wr_data[0];
        pol      <= wr_data[1];
        oe       <= wr_data[2];
        edge_sel <= wr_data[3];
      end
      if (wr_cmp) cmp <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      div   <= 1'b0;
    end else if (wr_cnt) begin
      count <= wr_data;
      div   <= edge_sel;
    end else if (tick) begin
      if (at_match) begin
        count <= '0;
        div   <= ~div;
      end else begin
        count <= count + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_d  <= 1'b0;
      oe_eff <= 1'b0;
    end else begin
      div_d <= div;
      if (act_edge) oe_eff <= oe;
    end
  end

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> count == $past(wr_data)); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && !tick) |=> ($stable(count) && $stable(div))); // R4

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && tick && !at_match) |=> (count == $past(count) + 1'b1) && $stable(div)); // R4

  AST_WRAP_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cnt && tick && at_match) |=> (count == '0) && (div != $past(div))); // R4

  AST_OE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_eff) |-> ($past(div) != $past(div, 2))); // R7

endmodule

// File: tb/sim_evgate_counter.sv
module sim_evgate_counter;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, evt_in = 1'b0, presc_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] count;
  logic clk_out, pin_out;
  int checks = 0, failures = 0;
  bit done = 0;

  evgate_counter #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .evt_in(evt_in), .presc_en(presc_en), .count(count), .clk_out(clk_out), .pin_out(pin_out));

  always #2 clk = ~clk;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic gate_pulses(input int n);
    if (n > 0) begin
      presc_en = 1'b1;
      idle(n);
      presc_en = 1'b0;
    end
    idle(1);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    idle(2);
    chk("R1 count", count, 0);
    chk("R1 clk_out", clk_out, 0);
    chk("R1 pin_out", pin_out, 0);
    rst_n = 1'b1;
    idle(2);
    // R1: compare resets to all ones -> 255 gate pulses then wrap
    wr(2'd0, 8'b0011);
    evt_in = 1'b1; idle(4);
    wr(2'd1, 8'd250);
    gate_pulses(6);
    chk("R1 cmp reset count", count, 0);
    chk("R1 cmp reset toggle", clk_out, 1);

    // R2/R3: mode sweep, compare = 255
    for (int m = 0; m < 4; m++) begin
      logic md, pl;
      int exp;
      md = m[1]; pl = m[0];
      wr(2'd0, {4'b0, 1'b0, 1'b0, pl, md});
      evt_in = md ? ~pl : 1'b0;
      idle(4);
      wr(2'd1, 8'd0);
      if (!md) begin
        presc_en = 1'b0;
        for (int t = 0; t < 5; t++) begin evt_in = ~evt_in; idle(3); end
        idle(3);
        exp = pl ? 3 : 2;
        chk(pl ? "R2 rising edges" : "R2 falling edges", count, exp);
      end else begin
        presc_en = 1'b1;
        idle(3);
        evt_in = pl; idle(7);
        evt_in = ~pl; idle(5);
        presc_en = 1'b0;
        idle(1);
        chk(pl ? "R3 high gate" : "R3 low gate", count, 7);
        // enabling level but presc_en low: no counts
        evt_in = pl; idle(6);
        chk("R3 no prescale no count", count, 7);
      end
    end

    // R4/R5: compare sweep in gate mode (high enables)
    evt_in = 1'b1; idle(4);
    for (int c = 0; c < 4; c++) begin
      wr(2'd2, c[W-1:0]);
      for (int es = 0; es < 2; es++) begin
        wr(2'd0, {4'b0, es[0], 1'b0, 1'b1, 1'b1});
        for (int p = 0; p <= 2 * (c + 1) + 1; p++) begin
          wr(2'd1, 8'd0);
          chk("R5 divider init", clk_out, es);
          gate_pulses(p);
          chk("R4 count", count, p % (c + 1));
          chk("R4 divider", clk_out, es ^ ((p / (c + 1)) & 1));
        end
      end
    end

    // R5: load arbitrary value
    wr(2'd2, 8'd255);
    wr(2'd1, 8'd77);
    chk("R5 load", count, 77);
    // R9: wr_sel 3 ignored
    wr(2'd3, 8'd5);
    chk("R9 sel3 count", count, 77);

    // R6: write wins over simultaneous count
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'd5; presc_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; presc_en = 1'b0;
    idle(1);
    chk("R6 priority", count, 5);

    // R7/R8: held-off enable, falling edge selected, compare 0
    wr(2'd2, 8'd0);
    wr(2'd0, 8'b0011);
    wr(2'd1, 8'd0);
    idle(2);
    wr(2'd0, 8'b0111);
    gate_pulses(1); idle(2);
    chk("R7 clk_out high", clk_out, 1);
    chk("R7 enable held off", pin_out, 0);
    gate_pulses(1); idle(2);
    chk("R8 pin low with clk low", pin_out, 0);
    gate_pulses(1); idle(2);
    chk("R8 pin follows", pin_out, 1);
    wr(2'd0, 8'b0011);
    idle(2);
    chk("R7 disable held off", pin_out, 1);
    gate_pulses(1); idle(2);
    gate_pulses(1); idle(2);
    chk("R7 disable took effect clk", clk_out, 1);
    chk("R8 pin held low", pin_out, 0);

    finish_up();
  end
endmodule